// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a bus-side agent into an asynchronous serial stream on a single line. A one-byte holding register takes each write. When the line is free, the byte is moved into a shift register and sent least significant bit first. The frame is a low start bit, five to eight data bits, an optional parity bit and a high stop period. Every bit lasts sixteen pulses of a 16x bit-rate clock enable. The word length, parity and stop length come from static configuration inputs.

A holding-empty flag and a one-cycle empty event tell the interrupt logic when the next byte can be written. The event fires as the start bit begins, so software has a whole character time to reload and keep the line busy. A clear-to-send input, held high, stops new characters without cutting one short. A break request replaces characters with all-low break characters. A transmitter enable forces the line to mark at once.

Top module: `ser_tx_core`

## Requirements
- R1: After reset, txd is 1 (mark), hold_empty is 1 and empty_evt is 0.
- R2: A character is sent as one start bit (0), then the data bits least significant first, then the parity bit if enabled, then stop (1). Each bit lasts 16 tick16 pulses. Holding-register bits above the word length are ignored.
- R3: cfg_wlen selects the data bit count: 2'b00 gives 8, 2'b01 gives 7, 2'b10 gives 6 and 2'b11 gives 5.
- R4: With cfg_par_en=1, cfg_par_mode selects the parity bit. 2'b00 makes the count of ones in data plus parity odd. 2'b01 makes it even. 2'b10 sends a constant 1 and 2'b11 a constant 0. With cfg_par_en=0, no parity bit is sent.
- R5: cfg_stop2=0 gives a stop period of 16 ticks. cfg_stop2=1 gives 24 ticks for 5 data bits without parity, 16 ticks for 8 data bits with parity, and 32 ticks in every other case.
- R6: A write (wr_en) clears hold_empty from the next cycle. Moving the byte into the shift register sets hold_empty and pulses empty_evt for one cycle. That cycle is the first cycle of the start bit (txd 0).
- R7: If a byte is waiting when the stop period ends, its start bit follows with no gap. Otherwise txd stays at mark. A byte written while the line idles starts its start bit on the clock after the write, whether or not a tick16 pulse falls then.
- R8: While cts_n is 1, the character in progress finishes with its parity and stop bits. No new character starts, hold_empty stays 0 if a byte is waiting, and empty_evt stays 0. The waiting byte starts on the first clock that cts_n is 0 again.
- R9: While brk_req is 1 and cts_n is 0, each new character slot is a break character. txd is held 0 for 16×(1 + data bits + parity bit) ticks plus the stop period of R5. A break character always runs to full length. When brk_req is 0 at its end, a 16-tick stop bit follows and normal sending resumes. A break does not consume the holding register.
- R10: If cts_n is 1 when a break character ends, txd goes to mark and stays there until cts_n returns to 0.
- R11: When tx_en is 0, txd is 1 from the next cycle, the character or break in progress is dropped and none starts. Writes still fill the holding register, and that byte is sent once tx_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate clock enable, one cycle per pulse |
| tx_en | input | 1 | Transmitter enable; 0 forces mark at once |
| cts_n | input | 1 | Clear to send, active low |
| brk_req | input | 1 | Request to send break characters |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_wlen | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | Parity kind |
| cfg_stop2 | input | 1 | Long stop period select |
| txd | output | 1 | Serial data line, 1 = mark |
| hold_empty | output | 1 | Holding register can take a byte |
| empty_evt | output | 1 | One-cycle pulse when a byte leaves the holding register |

## Verification
The checks assume the configuration inputs stay fixed while a character or break is on the line. They also assume all inputs are synchronous to clk. The stimulus changes configuration only after the line and holding register have drained. It writes a new byte only after seeing empty_evt, so a write never coincides with a transfer. A behavioural model builds every frame as a queue of per-tick line levels. It is compared with txd, hold_empty and empty_evt on every clock while tick16 runs at several rates.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5,
    ST_BSTOP = 3'd6
  } tx_state_e;

  typedef enum logic [1:0] {
    PM_ODD   = 2'b00,
    PM_EVEN  = 2'b01,
    PM_MARK  = 2'b10,
    PM_SPACE = 2'b11
  } par_mode_e;

endpackage

// File: rtl/ser_tx_fmt.sv
module ser_tx_fmt import ser_tx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CW     = 8,
  parameter int IW     = 4
) (
  input  logic [1:0]        wlen_code,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              stop_sel,
  input  logic [DATA_W-1:0] word,
  output logic [IW-1:0]     nbits,
  output logic [CW-1:0]     stop_ticks,
  output logic [CW-1:0]     brk_ticks,
  output logic              par_bit
);

  localparam logic [CW-1:0] T_ONE  = CW'(OVS);
  localparam logic [CW-1:0] T_MID  = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] T_TWO  = CW'(2 * OVS);
  localparam logic [IW-1:0] N_MAX  = IW'(DATA_W);
  localparam logic [IW-1:0] N_MIN  = IW'(DATA_W - 3);

  logic ones_odd;

  always_comb begin
    nbits    = N_MAX - IW'(wlen_code);
    ones_odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IW'(i) < nbits) ones_odd = ones_odd ^ word[i];
    end
    case (par_mode_e'(par_mode))
      PM_ODD:  par_bit = ~ones_odd;
      PM_EVEN: par_bit = ones_odd;
      PM_MARK: par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
    if (!stop_sel)                      stop_ticks = T_ONE;
    else if (nbits == N_MIN && !par_en) stop_ticks = T_MID;
    else if (nbits == N_MAX && par_en)  stop_ticks = T_ONE;
    else                                stop_ticks = T_TWO;
    brk_ticks = T_ONE * (CW'(nbits) + CW'(par_en) + CW'(1)) + stop_ticks;
  end

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_full
);

  logic              full_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    full_d = hold_full;
    data_d = hold_q;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (xfer) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else begin
      hold_full <= full_d;
      hold_q    <= data_d;
    end
  end

  // R6: a write always leaves the register occupied on the next cycle
  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hold_full);

endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq import ser_tx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CW     = 8,
  parameter int IW     = 4,
  parameter int BW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              brk_req,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_q,
  input  logic [IW-1:0]     nbits,
  input  logic              par_en,
  input  logic [CW-1:0]     stop_ticks,
  input  logic [CW-1:0]     brk_ticks,
  input  logic              par_bit,
  output logic [DATA_W-1:0] shreg_q,
  output logic              xfer,
  output logic              txd,
  output logic              empty_evt
);

  localparam logic [CW-1:0] T_BIT = CW'(OVS);

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     tcnt_q, tcnt_d, limit;
  logic [BW-1:0]     bidx_q, bidx_d;
  logic [DATA_W-1:0] shreg_d;
  logic              phase_end, try_start, last_bit;

  always_comb begin
    case (state_q)
      ST_STOP: limit = stop_ticks;
      ST_BRK:  limit = brk_ticks;
      default: limit = T_BIT;
    endcase
    phase_end = tick && (tcnt_q == limit - CW'(1));
    last_bit  = (IW'(bidx_q) == nbits - IW'(1));

    state_d   = state_q;
    tcnt_d    = tick ? tcnt_q + CW'(1) : tcnt_q;
    bidx_d    = bidx_q;
    shreg_d   = shreg_q;
    xfer      = 1'b0;
    try_start = (state_q == ST_IDLE);

    if (phase_end) begin
      tcnt_d = '0;
      case (state_q)
        ST_START: begin
          state_d = ST_DATA;
          bidx_d  = '0;
        end
        ST_DATA: begin
          if (last_bit) state_d = par_en ? ST_PAR : ST_STOP;
          else          bidx_d  = bidx_q + BW'(1);
        end
        ST_PAR:            state_d = ST_STOP;
        ST_STOP, ST_BSTOP: try_start = 1'b1;
        ST_BRK: begin
          if (brk_req) try_start = 1'b1;
          else         state_d   = ST_BSTOP;
        end
        default:           state_d = ST_IDLE;
      endcase
    end

    if (try_start) begin
      tcnt_d = '0;
      if (!cts_n && brk_req) begin
        state_d = ST_BRK;
      end else if (!cts_n && hold_full) begin
        state_d = ST_START;
        shreg_d = hold_q;
        xfer    = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
    end

    if (!tx_en) begin
      state_d = ST_IDLE;
      tcnt_d  = '0;
      xfer    = 1'b0;
    end
  end

  always_comb begin
    case (state_q)
      ST_START, ST_BRK: txd = 1'b0;
      ST_DATA:          txd = shreg_q[bidx_q];
      ST_PAR:           txd = par_bit;
      default:          txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      bidx_q    <= '0;
      shreg_q   <= '0;
      empty_evt <= 1'b0;
    end else begin
      state_q   <= state_d;
      tcnt_q    <= tcnt_d;
      bidx_q    <= bidx_d;
      shreg_q   <= shreg_d;
      empty_evt <= xfer;
    end
  end

  // R11: a disabled transmitter shows mark on the following cycle
  a_r11_disable_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd);

endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              brk_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_stop2,
  output logic              txd,
  output logic              hold_empty,
  output logic              empty_evt
);

  localparam int CW = $clog2(OVS * (DATA_W + 4) + 1);
  localparam int IW = $clog2(DATA_W + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [DATA_W-1:0] hold_q, shreg_q;
  logic              hold_full, xfer, par_bit;
  logic [IW-1:0]     nbits;
  logic [CW-1:0]     stop_ticks, brk_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer(xfer), .hold_q(hold_q), .hold_full(hold_full)
  );

  ser_tx_fmt #(.DATA_W(DATA_W), .OVS(OVS), .CW(CW), .IW(IW)) u_fmt (
    .wlen_code(cfg_wlen), .par_en(cfg_par_en), .par_mode(cfg_par_mode),
    .stop_sel(cfg_stop2), .word(shreg_q), .nbits(nbits),
    .stop_ticks(stop_ticks), .brk_ticks(brk_ticks), .par_bit(par_bit)
  );

  ser_tx_seq #(.DATA_W(DATA_W), .OVS(OVS), .CW(CW), .IW(IW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick16), .tx_en(tx_en),
    .cts_n(cts_n), .brk_req(brk_req), .hold_full(hold_full), .hold_q(hold_q),
    .nbits(nbits), .par_en(cfg_par_en), .stop_ticks(stop_ticks),
    .brk_ticks(brk_ticks), .par_bit(par_bit), .shreg_q(shreg_q),
    .xfer(xfer), .txd(txd), .empty_evt(empty_evt)
  );

  assign hold_empty = ~hold_full;

  // R6: the empty event coincides with the first cycle of a start bit
  a_r6_evt_on_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    empty_evt |-> !txd);

  // R8: no byte leaves the holding register unless clear to send
  a_r8_evt_needs_cts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    empty_evt |-> $past(!cts_n));

endmodule

// File: tb/ser_tx_core_tb.sv
module ser_tx_core_tb;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, tx_en = 1'b1;
  logic       cts_n = 1'b0, brk_req = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_wlen = '0, cfg_par_mode = '0;
  logic       cfg_par_en = 1'b0, cfg_stop2 = 1'b0;
  logic       txd, hold_empty, empty_evt;

  always #10 clk = ~clk;

  ser_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en), .cts_n(cts_n),
    .brk_req(brk_req), .wr_en(wr_en), .wr_data(wr_data), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode), .cfg_stop2(cfg_stop2),
    .txd(txd), .hold_empty(hold_empty), .empty_evt(empty_evt)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;
  int    tick_div = 1, tdiv = 0;

  always @(negedge clk) begin
    if (tdiv >= tick_div - 1) begin tick16 = 1'b1; tdiv = 0; end
    else begin tick16 = 1'b0; tdiv++; end
  end

  // behavioural model: each queue entry is the line level for one tick
  localparam int K_NONE = 0, K_CHR = 1, K_BRK = 2, K_BST = 3;
  bit         mq[$];
  int         m_kind = K_NONE, m_rc = 0;
  bit         m_full = 0, m_evt = 0;
  logic [7:0] m_data = '0;

  function automatic int nbits_now();
    return 8 - int'(cfg_wlen);
  endfunction

  function automatic int stop_now();
    int n = nbits_now();
    if (!cfg_stop2) return 16;
    if (n == 5 && !cfg_par_en) return 24;
    if (n == 8 && cfg_par_en) return 16;
    return 32;
  endfunction

  function automatic void push_n(bit v, int n);
    for (int i = 0; i < n; i++) mq.push_back(v);
  endfunction

  function automatic void push_char(logic [7:0] d);
    int n = nbits_now();
    bit acc = 0;
    bit p;
    push_n(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      push_n(d[i], 16);
      acc ^= d[i];
    end
    if (cfg_par_en) begin
      case (cfg_par_mode)
        2'b00:   p = ~acc;
        2'b01:   p = acc;
        2'b10:   p = 1'b1;
        default: p = 1'b0;
      endcase
      push_n(p, 16);
    end
    push_n(1'b1, stop_now());
  endfunction

  always @(posedge clk) begin
    bit ended;
    bit xf;
    ended = 0;
    xf    = 0;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc++;
      mq.delete();
      m_kind = K_NONE; m_full = 0; m_data = '0; m_evt = 0;
    end else begin
      if (!tx_en) begin
        mq.delete();
      end else begin
        if (tick16 && mq.size() > 0) begin
          void'(mq.pop_front());
          if (mq.size() == 0) ended = 1;
        end
        if (mq.size() == 0) begin
          if (ended && m_kind == K_BRK && !brk_req) begin
            push_n(1'b1, 16); m_kind = K_BST;
          end else if (!cts_n && brk_req) begin
            push_n(1'b0, 16 * (1 + nbits_now() + int'(cfg_par_en)) + stop_now());
            m_kind = K_BRK;
          end else if (!cts_n && m_full) begin
            push_char(m_data); m_kind = K_CHR; xf = 1;
          end
        end
      end
      if (wr_en) begin m_full = 1; m_data = wr_data; end
      else if (xf) m_full = 0;
      m_evt = xf;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit et;
      et = (mq.size() > 0) ? mq[0] : 1'b1;
      checks++;
      if (txd !== et || hold_empty !== !m_full || empty_evt !== m_evt) begin
        errors++;
        $display("FAIL %s: txd=%b exp %b, hold_empty=%b exp %b, empty_evt=%b exp %b at %0t",
                 cur_req, txd, et, hold_empty, !m_full, empty_evt, m_evt, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish (%s)", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_evt();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (empty_evt) return;
    end
    checks++; errors++;
    $display("FAIL %s: empty_evt=0 exp 1 (no transfer seen)", cur_req);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (mq.size() == 0 && !m_full) begin clocks(3); return; end
    end
    checks++; errors++;
    $display("FAIL %s: line busy=1 exp 0 (did not drain)", cur_req);
  endtask

  task automatic set_cfg(logic [1:0] wl, logic pe, logic [1:0] pm, logic st);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_mode = pm; cfg_stop2 = st;
  endtask

  initial begin
    cur_req = "R1";
    clocks(3);
    rst_n = 1'b1;
    clocks(4);
    checks++;
    if (txd !== 1'b1 || hold_empty !== 1'b1 || empty_evt !== 1'b0) begin
      errors++;
      $display("FAIL R1: txd=%b hold_empty=%b empty_evt=%b exp 1 1 0", txd, hold_empty, empty_evt);
    end

    cur_req = "R2"; set_cfg(2'b00, 0, 2'b00, 0);
    wr(8'hA5); wait_quiet();
    tick_div = 2; wr(8'h3C); wait_quiet();

    cur_req = "R3"; tick_div = 1;
    for (int wl = 1; wl < 4; wl++) begin
      set_cfg(2'(wl), 0, 2'b00, 0);
      wr(8'hE6); wait_quiet();
    end

    cur_req = "R4"; tick_div = 3;
    for (int pm = 0; pm < 4; pm++) begin
      set_cfg(2'b01, 1, 2'(pm), 0);
      wr(8'h53); wait_quiet();
      wr(8'h52); wait_quiet();
    end

    cur_req = "R5"; tick_div = 1;
    set_cfg(2'b11, 0, 2'b00, 1); wr(8'h15); wait_quiet();
    set_cfg(2'b00, 1, 2'b01, 1); wr(8'hC3); wait_quiet();
    set_cfg(2'b10, 0, 2'b00, 1); wr(8'h2A); wait_quiet();
    set_cfg(2'b11, 1, 2'b00, 1); wr(8'h0F); wait_quiet();

    cur_req = "R6"; set_cfg(2'b00, 0, 2'b00, 0);
    wr(8'h11); wait_evt();
    cur_req = "R7";
    wr(8'h22); wait_evt();
    wr(8'h33); wait_quiet();
    clocks(50); wr(8'h44); wait_quiet();

    cur_req = "R8"; tick_div = 2;
    wr(8'h5A); wait_evt(); wr(8'h6B);
    clocks(20); cts_n = 1'b1;
    clocks(900); cts_n = 1'b0;
    wait_quiet();

    cur_req = "R9"; tick_div = 1;
    brk_req = 1'b1; clocks(3); brk_req = 1'b0;
    wait_quiet(); clocks(200);
    wr(8'h81); wait_evt(); brk_req = 1'b1;
    clocks(500); wr(8'h7E); clocks(40); brk_req = 1'b0;
    wait_quiet();

    cur_req = "R10"; set_cfg(2'b10, 1, 2'b00, 1);
    brk_req = 1'b1; clocks(40); cts_n = 1'b1;
    clocks(400); cts_n = 1'b0;
    clocks(50); brk_req = 1'b0;
    wait_quiet();

    cur_req = "R11"; set_cfg(2'b00, 0, 2'b00, 0); tick_div = 2;
    wr(8'hC3); wait_evt(); clocks(60);
    tx_en = 1'b0; clocks(5);
    wr(8'h99); clocks(30);
    tx_en = 1'b1;
    wait_quiet();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule